// File: doc/BRIEF.md
# Snooping MESI Coherence Subsystem

This block holds several private, direct-mapped, write-back cache models that share one atomic bus and one backing memory. Every cache line carries a four-state coherence tag (Invalid, Shared, Exclusive, Modified). A processor port asks for a one-word load or store. When the line is held with enough permission, the cache completes the access locally. Otherwise the cache requests the shared bus. A rotating-priority arbiter grants one cache per cycle. The whole bus transaction finishes inside the granted cycle: address broadcast, snoop responses from every other cache, data supply from a dirty owner, and any writeback.

A granted cache issues one of three commands: a read miss, a write miss (read for ownership), or an upgrade. Every other cache compares the broadcast address with its own line and reports a hit on a wired-OR shared line. The dirty owner supplies the line and the data is written to memory at the same edge. Copies held by other caches are demoted or invalidated. An observation port shows each bus transaction, for system-level monitoring.

Top module: `mesi_snoop_top`

## Requirements
- R1: After reset every line is Invalid, no port acknowledges, the bus is idle, and the memory word at address a holds (13*a+7) modulo 2^DATA_W.
- R2: At most one cache is granted per cycle. A granted cache acknowledges in that cycle. The grant search starts at cache 0 after reset and, after a grant to cache k, resumes at cache k+1 modulo the cache count.
- R3: A read miss issues bus command 1 (read). The shared flag is raised exactly when another cache holds a valid copy. The line fills as Exclusive without the flag and as Shared with it.
- R4: A store to an Exclusive line completes with no bus transaction and leaves the line Modified.
- R5: A store to a Shared line issues bus command 3 (upgrade) and leaves the line Modified.
- R6: A store that misses issues bus command 2 (read for ownership) and leaves the line Modified.
- R7: Loads that hit in M, E or S, and stores that hit in M, complete without a bus transaction.
- R8: A snooped read demotes an M or E copy to Shared. An M copy supplies its data to the requester and to memory.
- R9: A snooped read-for-ownership or upgrade invalidates every other copy, and an M copy supplies its data first.
- R10: A line is never held in M or E by one cache while any other cache holds a valid copy of it.
- R11: Replacing a Modified line writes its data back to memory during the transaction that replaces it.
- R12: Every load returns the value of the most recent completed store to that address, or the reset value when no store has completed.

The address is split into a low set index of INDEX_W bits and a tag in the remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | N_CACHE | Per-port access request, held until acknowledged |
| cpu_we | input | N_CACHE | Per-port store select (1 = store) |
| cpu_addr | input | N_CACHE*ADDR_W | Per-port word address, port p at bits p*ADDR_W |
| cpu_wdata | input | N_CACHE*DATA_W | Per-port store data |
| cpu_ack | output | N_CACHE | Access completes at the coming clock edge |
| cpu_rdata | output | N_CACHE*DATA_W | Load data, valid while cpu_ack is high |
| bus_valid | output | 1 | A bus transaction occurs this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read for ownership, 3 upgrade |
| bus_addr | output | ADDR_W | Address of the transaction |
| bus_owner | output | $clog2(N_CACHE) | Index of the granted cache |
| bus_shared | output | 1 | Wired-OR snoop hit response |

## Verification
The assertions check several properties on every cycle. At most one grant may be active, and a granted cache must complete. The single-writer and exclusivity invariants must hold across all caches and sets. After each bus transaction, the requester's line state must match the command and the shared response, and a write-type transaction must leave no other copy. The bench's scenarios cover the rest: silent E-to-M upgrades, S upgrades, write misses that evict a dirty victim whose data must later come back from memory, rotation of the grant order, and load values under random traffic from all ports against a flat golden memory.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPG  = 2'd3
    } bus_cmd_e;

    // Reset contents of backing memory; caller truncates to its data width.
    function automatic logic [31:0] mem_init_word(input int unsigned a);
        return 32'(a * 13 + 7);
    endfunction

endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic          found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int o = 0; o < N; o++) begin
            int k;
            k = (int'(ptr_q) + o) % N;
            if (!found && req[k]) begin
                gnt[k] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (gnt[i]) ptr_q <= PW'((i + 1) % N);
            end
        end
    end

endmodule

// File: rtl/mesi_mem.sv
module mesi_mem
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fl_en,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    // The flush and the victim writeback never target the same word.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem_q[a] <= DATA_W'(mem_init_word(a));
            end
        end else begin
            if (fl_en) mem_q[fl_addr] <= fl_data;
            if (wb_en) mem_q[wb_addr] <= wb_data;
        end
    end

endmodule

// File: rtl/mesi_cache.sv
module mesi_cache
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int INDEX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    // processor side
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic                        cpu_ack,
    output logic [DATA_W-1:0]           cpu_rdata,
    // requester side of the bus
    output logic                        bus_req,
    output logic [1:0]                  bus_req_cmd,
    input  logic                        bus_gnt,
    input  logic [DATA_W-1:0]           fill_data,
    input  logic                        fill_shared,
    output logic                        wb_valid,
    output logic [ADDR_W-1:0]           wb_addr,
    output logic [DATA_W-1:0]           wb_data,
    // snooper side of the bus
    input  logic                        snp_valid,
    input  logic [1:0]                  snp_cmd,
    input  logic [ADDR_W-1:0]           snp_addr,
    output logic                        snp_hit,
    output logic                        snp_flush,
    output logic [DATA_W-1:0]           snp_data,
    // line state observation
    output logic [(1<<INDEX_W)*2-1:0]   st_vec,
    output logic [(1<<INDEX_W)*(ADDR_W-INDEX_W)-1:0] tag_vec
);
    localparam int SETS  = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W;

    line_st_e          st_q  [SETS];
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];

    logic [INDEX_W-1:0] idx, sidx;
    logic [TAG_W-1:0]   tg, stg;
    logic               present, need_bus, set_clash, local_ok, s_match;

    assign idx = cpu_addr[INDEX_W-1:0];
    assign tg  = cpu_addr[ADDR_W-1:INDEX_W];
    assign sidx = snp_addr[INDEX_W-1:0];
    assign stg  = snp_addr[ADDR_W-1:INDEX_W];

    assign present  = (st_q[idx] != ST_I) && (tag_q[idx] == tg);
    assign need_bus = cpu_req && (!present || (cpu_we && st_q[idx] == ST_S));
    // A local hit waits while another cache's transaction touches this set.
    assign set_clash = snp_valid && (sidx == idx);
    assign local_ok  = cpu_req && !need_bus && !set_clash;

    assign bus_req     = need_bus;
    assign bus_req_cmd = present ? CMD_UPG : (cpu_we ? CMD_RDX : CMD_RD);

    assign cpu_ack   = local_ok || bus_gnt;
    assign cpu_rdata = present ? dat_q[idx] : fill_data;

    // Victim writeback rides along with this cache's own transaction.
    assign wb_valid = bus_gnt && (st_q[idx] == ST_M) && (tag_q[idx] != tg);
    assign wb_addr  = {tag_q[idx], idx};
    assign wb_data  = dat_q[idx];

    assign s_match   = snp_valid && (st_q[sidx] != ST_I) && (tag_q[sidx] == stg);
    assign snp_hit   = s_match;
    assign snp_flush = s_match && (st_q[sidx] == ST_M);
    assign snp_data  = dat_q[sidx];

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            st_vec[s*2 +: 2]         = st_q[s];
            tag_vec[s*TAG_W +: TAG_W] = tag_q[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                st_q[s]  <= ST_I;
                tag_q[s] <= '0;
                dat_q[s] <= '0;
            end
        end else begin
            if (s_match) begin
                st_q[sidx] <= (snp_cmd == CMD_RD) ? ST_S : ST_I;
            end
            if (bus_gnt) begin
                tag_q[idx] <= tg;
                if (present || cpu_we) begin
                    dat_q[idx] <= cpu_wdata;
                    st_q[idx]  <= ST_M;
                end else begin
                    dat_q[idx] <= fill_data;
                    st_q[idx]  <= fill_shared ? ST_S : ST_E;
                end
            end else if (local_ok && cpu_we) begin
                dat_q[idx] <= cpu_wdata;
                st_q[idx]  <= ST_M;
            end
        end
    end

endmodule

// File: rtl/mesi_snoop_top.sv
module mesi_snoop_top
    import mesi_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int INDEX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_CACHE-1:0]          cpu_req,
    input  logic [N_CACHE-1:0]          cpu_we,
    input  logic [N_CACHE*ADDR_W-1:0]   cpu_addr,
    input  logic [N_CACHE*DATA_W-1:0]   cpu_wdata,
    output logic [N_CACHE-1:0]          cpu_ack,
    output logic [N_CACHE*DATA_W-1:0]   cpu_rdata,
    output logic                        bus_valid,
    output logic [1:0]                  bus_cmd,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic [$clog2(N_CACHE)-1:0]  bus_owner,
    output logic                        bus_shared
);
    localparam int SETS  = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int OW    = $clog2(N_CACHE);

    logic [N_CACHE-1:0]             need, gnt, snp_hit, snp_flush, wb_v;
    logic [N_CACHE-1:0][1:0]        req_cmd;
    logic [N_CACHE-1:0][ADDR_W-1:0] wb_a;
    logic [N_CACHE-1:0][DATA_W-1:0] wb_d, snp_d;
    logic [N_CACHE*SETS*2-1:0]      st_all;
    logic [N_CACHE*SETS*TAG_W-1:0]  tag_all;

    logic              any_flush, sel_wb_v;
    logic [DATA_W-1:0] flush_data, fill_data, mem_rd, sel_wb_d;
    logic [ADDR_W-1:0] sel_wb_a;

    mesi_rr_arb #(.N(N_CACHE)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (need),
        .gnt (gnt)
    );

    always_comb begin
        bus_cmd   = CMD_NONE;
        bus_addr  = '0;
        bus_owner = '0;
        sel_wb_v  = 1'b0;
        sel_wb_a  = '0;
        sel_wb_d  = '0;
        for (int i = 0; i < N_CACHE; i++) begin
            if (gnt[i]) begin
                bus_cmd   = req_cmd[i];
                bus_addr  = cpu_addr[i*ADDR_W +: ADDR_W];
                bus_owner = OW'(i);
                sel_wb_v  = wb_v[i];
                sel_wb_a  = wb_a[i];
                sel_wb_d  = wb_d[i];
            end
        end
    end

    assign bus_valid  = |gnt;
    assign bus_shared = |snp_hit;
    assign any_flush  = |snp_flush;

    always_comb begin
        flush_data = '0;
        for (int i = 0; i < N_CACHE; i++) begin
            if (snp_flush[i]) flush_data = flush_data | snp_d[i];
        end
    end

    assign fill_data = any_flush ? flush_data : mem_rd;

    generate
        for (genvar g = 0; g < N_CACHE; g++) begin : g_cache
            mesi_cache #(
                .ADDR_W  (ADDR_W),
                .DATA_W  (DATA_W),
                .INDEX_W (INDEX_W)
            ) u_cache (
                .clk         (clk),
                .rst         (rst),
                .cpu_req     (cpu_req[g]),
                .cpu_we      (cpu_we[g]),
                .cpu_addr    (cpu_addr[g*ADDR_W +: ADDR_W]),
                .cpu_wdata   (cpu_wdata[g*DATA_W +: DATA_W]),
                .cpu_ack     (cpu_ack[g]),
                .cpu_rdata   (cpu_rdata[g*DATA_W +: DATA_W]),
                .bus_req     (need[g]),
                .bus_req_cmd (req_cmd[g]),
                .bus_gnt     (gnt[g]),
                .fill_data   (fill_data),
                .fill_shared (bus_shared),
                .wb_valid    (wb_v[g]),
                .wb_addr     (wb_a[g]),
                .wb_data     (wb_d[g]),
                .snp_valid   (bus_valid & ~gnt[g]),
                .snp_cmd     (bus_cmd),
                .snp_addr    (bus_addr),
                .snp_hit     (snp_hit[g]),
                .snp_flush   (snp_flush[g]),
                .snp_data    (snp_d[g]),
                .st_vec      (st_all[g*SETS*2 +: SETS*2]),
                .tag_vec     (tag_all[g*SETS*TAG_W +: SETS*TAG_W])
            );
        end
    endgenerate

    mesi_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (bus_addr),
        .rd_data (mem_rd),
        .fl_en   (any_flush),
        .fl_addr (bus_addr),
        .fl_data (flush_data),
        .wb_en   (sel_wb_v),
        .wb_addr (sel_wb_a),
        .wb_data (sel_wb_d)
    );

endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk
    import mesi_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int ADDR_W  = 6,
    parameter int INDEX_W = 2
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [N_CACHE-1:0]                             gnt,
    input  logic [N_CACHE-1:0]                             cpu_ack,
    input  logic                                           bus_valid,
    input  logic [1:0]                                     bus_cmd,
    input  logic [ADDR_W-1:0]                              bus_addr,
    input  logic [$clog2(N_CACHE)-1:0]                     bus_owner,
    input  logic                                           bus_shared,
    input  logic [N_CACHE*(1<<INDEX_W)*2-1:0]              st_all,
    input  logic [N_CACHE*(1<<INDEX_W)*(ADDR_W-INDEX_W)-1:0] tag_all
);
    localparam int SETS  = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int OW    = $clog2(N_CACHE);

    function automatic logic [1:0] st_at(input int c, input int s);
        return st_all[(c*SETS + s)*2 +: 2];
    endfunction

    function automatic logic [TAG_W-1:0] tag_at(input int c, input int s);
        return tag_all[(c*SETS + s)*TAG_W +: TAG_W];
    endfunction

    logic swmr_ok, excl_ok, own_ok, others_clear;
    logic pend;
    logic [1:0] p_cmd, p_exp;
    logic [OW-1:0] p_own;
    logic [INDEX_W-1:0] p_idx;
    logic [TAG_W-1:0] p_tag;

    always_comb begin
        swmr_ok = 1'b1;
        excl_ok = 1'b1;
        for (int s = 0; s < SETS; s++) begin
            for (int a = 0; a < N_CACHE; a++) begin
                for (int b = a + 1; b < N_CACHE; b++) begin
                    if (st_at(a, s) != ST_I && st_at(b, s) != ST_I &&
                        tag_at(a, s) == tag_at(b, s)) begin
                        if (st_at(a, s) == ST_M && st_at(b, s) == ST_M) swmr_ok = 1'b0;
                        if (st_at(a, s) inside {ST_M, ST_E} ||
                            st_at(b, s) inside {ST_M, ST_E}) excl_ok = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            p_cmd <= '0;
            p_exp <= '0;
            p_own <= '0;
            p_idx <= '0;
            p_tag <= '0;
        end else begin
            pend  <= bus_valid;
            p_cmd <= bus_cmd;
            p_exp <= (bus_cmd == CMD_RD) ? (bus_shared ? ST_S : ST_E) : ST_M;
            p_own <= bus_owner;
            p_idx <= bus_addr[INDEX_W-1:0];
            p_tag <= bus_addr[ADDR_W-1:INDEX_W];
        end
    end

    always_comb begin
        own_ok = (st_at(int'(p_own), int'(p_idx)) == p_exp) &&
                 (tag_at(int'(p_own), int'(p_idx)) == p_tag);
        others_clear = 1'b1;
        for (int c = 0; c < N_CACHE; c++) begin
            if (c != int'(p_own) && st_at(c, int'(p_idx)) != ST_I &&
                tag_at(c, int'(p_idx)) == p_tag) others_clear = 1'b0;
        end
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));

    // R2
    gnt_ack_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> cpu_ack[bus_owner]);

    // R10
    single_writer_chk: assert property (@(posedge clk) disable iff (rst) swmr_ok);

    // R10
    exclusive_chk: assert property (@(posedge clk) disable iff (rst) excl_ok);

    // R3
    fill_state_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && p_cmd == CMD_RD) |-> own_ok);

    // R6
    own_modified_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && p_cmd != CMD_RD) |-> own_ok);

    // R9
    invalidate_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && p_cmd != CMD_RD) |-> others_clear);

endmodule

bind mesi_snoop_top mesi_snoop_chk #(
    .N_CACHE (N_CACHE),
    .ADDR_W  (ADDR_W),
    .INDEX_W (INDEX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gnt        (gnt),
    .cpu_ack    (cpu_ack),
    .bus_valid  (bus_valid),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_owner  (bus_owner),
    .bus_shared (bus_shared),
    .st_all     (st_all),
    .tag_all    (tag_all)
);

// File: tb/mesi_snoop_top_tb_top.sv
`timescale 1ns/1ps
module mesi_snoop_top_tb_top;
    localparam int N  = 4;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam int OW = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]    cpu_req = '0;
    logic [N-1:0]    cpu_we = '0;
    logic [N*AW-1:0] cpu_addr = '0;
    logic [N*DW-1:0] cpu_wdata = '0;
    logic [N-1:0]    cpu_ack;
    logic [N*DW-1:0] cpu_rdata;
    logic            bus_valid, bus_shared;
    logic [1:0]      bus_cmd;
    logic [AW-1:0]   bus_addr;
    logic [OW-1:0]   bus_owner;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int exp_ptr = 0;
    logic [DW-1:0] gold [1<<AW];

    always #2 clk = ~clk;

    mesi_snoop_top #(.N_CACHE(N), .ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_owner(bus_owner), .bus_shared(bus_shared)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One access on one port; returns the observed results.
    task automatic acc(input int p, input bit we, input int a, input int d,
                       output logic [DW-1:0] rd, output bit used,
                       output logic [1:0] cmd, output bit shr);
        int waits = 0;
        @(posedge clk); #1;
        cpu_req[p] = 1'b1;
        cpu_we[p]  = we;
        cpu_addr[p*AW +: AW]  = AW'(a);
        cpu_wdata[p*DW +: DW] = DW'(d);
        forever begin
            @(negedge clk); #1;
            if (cpu_ack[p]) break;
            waits++;
            if (waits > 100) begin
                chk(1'b0, "R2 access hung", 32'(waits), 0);
                break;
            end
        end
        rd   = cpu_rdata[p*DW +: DW];
        used = bus_valid && (int'(bus_owner) == p);
        cmd  = bus_cmd;
        shr  = bus_shared;
        if (used) exp_ptr = (p + 1) % N;
        if (we) gold[a] = DW'(d);
        @(posedge clk); #1;
        cpu_req[p] = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] rd;
        bit used, shr;
        logic [1:0] cmd;
        bit done [N];
        bit [N-1:0] active;

        for (int a = 0; a < (1 << AW); a++) gold[a] = DW'(a * 13 + 7);
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: idle after reset
        @(negedge clk); #1;
        chk(cpu_ack == '0, "R1 ack idle", 32'(cpu_ack), 0);
        chk(bus_valid == 1'b0, "R1 bus idle", 32'(bus_valid), 0);

        // R1 R3: first read miss alone fills exclusive
        acc(0, 0, 5, 0, rd, used, cmd, shr);
        chk(rd == gold[5], "R1 reset memory value", rd, gold[5]);
        chk(used && cmd == 2'd1 && !shr, "R3 read miss no sharer",
            {used, cmd, shr}, {1'b1, 2'd1, 1'b0});
        // R4: store to E is silent
        acc(0, 1, 5, 16'h1111, rd, used, cmd, shr);
        chk(!used, "R4 silent E store", 32'(used), 0);
        // R7: load hit in M
        acc(0, 0, 5, 0, rd, used, cmd, shr);
        chk(!used && rd == 16'h1111, "R7 load hit M", {used, rd}, {1'b0, 16'h1111});
        // R8: remote read of M line, owner supplies data
        acc(1, 0, 5, 0, rd, used, cmd, shr);
        chk(used && cmd == 2'd1 && shr, "R8 snooped read shared",
            {used, cmd, shr}, {1'b1, 2'd1, 1'b1});
        chk(rd == 16'h1111, "R8 dirty data supplied", rd, 16'h1111);
        // R5: store to S upgrades
        acc(0, 1, 5, 16'h2222, rd, used, cmd, shr);
        chk(used && cmd == 2'd3, "R5 upgrade from S", {used, cmd}, {1'b1, 2'd3});
        // R7: store hit in M is silent
        acc(0, 1, 5, 16'h2323, rd, used, cmd, shr);
        chk(!used, "R7 store hit M", 32'(used), 0);
        // R9: cache 1 was invalidated, must miss again
        acc(1, 0, 5, 0, rd, used, cmd, shr);
        chk(used && cmd == 2'd1 && shr, "R9 invalidated copy misses",
            {used, cmd, shr}, {1'b1, 2'd1, 1'b1});
        chk(rd == 16'h2323, "R12 latest store seen", rd, 16'h2323);
        // R6: write miss
        acc(2, 1, 9, 16'h3333, rd, used, cmd, shr);
        chk(used && cmd == 2'd2, "R6 write miss rdx", {used, cmd}, {1'b1, 2'd2});
        acc(2, 1, 9, 16'h3434, rd, used, cmd, shr);
        chk(!used, "R6 line ends modified", 32'(used), 0);
        // R11: evict dirty line 9 via set conflict with 13
        acc(2, 1, 13, 16'h4444, rd, used, cmd, shr);
        chk(used && cmd == 2'd2, "R11 conflict write miss", {used, cmd}, {1'b1, 2'd2});
        acc(3, 0, 9, 0, rd, used, cmd, shr);
        chk(used && !shr && rd == 16'h3434, "R11 writeback reached memory",
            {used, shr, rd}, {1'b1, 1'b0, 16'h3434});
        // R3: line filled exclusive, store silent
        acc(3, 1, 9, 16'h5555, rd, used, cmd, shr);
        chk(!used, "R3 exclusive fill allows silent store", 32'(used), 0);
        // R8: remote read of line 13 held M by cache 2
        acc(1, 0, 13, 0, rd, used, cmd, shr);
        chk(shr && rd == 16'h4444, "R8 shared fill data", {shr, rd}, {1'b1, 16'h4444});
        acc(2, 0, 13, 0, rd, used, cmd, shr);
        chk(!used && rd == 16'h4444, "R7 load hit S", {used, rd}, {1'b0, 16'h4444});

        // R2: all ports miss together; grants rotate from the expected pointer
        @(posedge clk); #1;
        for (int p = 0; p < N; p++) begin
            cpu_req[p] = 1'b1;
            cpu_we[p]  = 1'b0;
            cpu_addr[p*AW +: AW] = AW'(48 + p);
        end
        for (int k = 0; k < N; k++) begin
            int e;
            e = exp_ptr;
            @(negedge clk); #1;
            chk(bus_valid && int'(bus_owner) == e, "R2 rotating grant",
                32'(bus_owner), 32'(e));
            chk(cpu_rdata[e*DW +: DW] == gold[48 + e], "R12 miss data",
                cpu_rdata[e*DW +: DW], gold[48 + e]);
            exp_ptr = (e + 1) % N;
            @(posedge clk); #1;
            cpu_req[e] = 1'b0;
        end

        // R12: random concurrent traffic against the golden memory
        active = '0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk); #1;
            for (int p = 0; p < N; p++) begin
                int a;
                a = int'(cpu_addr[p*AW +: AW]);
                done[p] = cpu_req[p] && cpu_ack[p];
                if (done[p] && !cpu_we[p])
                    chk(cpu_rdata[p*DW +: DW] == gold[a], "R12 random load",
                        cpu_rdata[p*DW +: DW], gold[a]);
            end
            for (int p = 0; p < N; p++) begin
                if (done[p] && cpu_we[p])
                    gold[int'(cpu_addr[p*AW +: AW])] = cpu_wdata[p*DW +: DW];
            end
            @(posedge clk); #1;
            for (int p = 0; p < N; p++) begin
                if (done[p] || !active[p]) begin
                    if ($urandom % 4 == 0) begin
                        cpu_req[p] = 1'b0;
                        active[p]  = 1'b0;
                    end else begin
                        cpu_req[p] = 1'b1;
                        active[p]  = 1'b1;
                        cpu_we[p]  = 1'($urandom % 2);
                        cpu_addr[p*AW +: AW]  = AW'($urandom % 16);
                        cpu_wdata[p*DW +: DW] = DW'($urandom);
                    end
                end
            end
        end
        cpu_req = '0;

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R2 watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

endmodule